// File: doc/BRIEF.md
# Trace Link Test Pattern Generator

This block sits at the end of a trace path, just before the parallel trace output pins. In normal use it passes the trace word through to the port. On request it replaces that word with a known bit sequence, so that an external capture device can check every lane of the link. The port width in use (1 to `PORT_W` lanes) comes in on an input. Every word driven out is masked to that width.

A 32-bit control word holds two things: a run mode and a set of pattern enables. The run mode is off, timed or continuous. Up to four pattern types can be enabled at the same time. When several are enabled, the generator plays each one through its whole sequence before it moves on to the next enabled one. It goes in ascending enable-bit order and wraps round at the end.

Timed mode takes its length from an 8-bit repeat value that software programs. The block copies that value into a private down-counter. When the count runs out, the mode returns to off by itself. Software reads back the mode that is live at the time, and it reads back the programmed repeat value.

Top module: `trace_pattern_gen`

## Requirements
- R1: After reset the control readback is 0 (mode off, no patterns) and the repeat readback is 0. `pat_active` is low and `port_data` equals `trace_data` masked to the port width.
- R2: Control bits [17:16] select the mode: 00 off, 01 timed, 10 continuous. A written 11 is stored as continuous and reads back as 10. Bits [3:0] are the pattern enables. The readback word places the live mode in [17:16] and the enables in [3:0], with every other bit zero.
- R3: The pattern words are masked to the port width W, and each pattern has its own sequence:
  - Enable bit 0 gives walking ones. Step i has only bit i set, and the sequence is W steps long.
  - Enable bit 1 gives walking zeros. Step i has only bit i clear, and the sequence is W steps long.
  - Enable bit 2 alternates 0xAA.. (odd bits set) then 0x55.., which is 2 steps.
  - Enable bit 3 gives all ones then all zeros, which is 2 steps.
- R4: When several patterns are enabled, each one runs its full sequence once. The generator then moves to the next enabled pattern in ascending bit order and wraps round from the highest to the lowest.
- R5: Every control write with an active mode restarts the output at step 0 of the lowest enabled pattern. That step appears in the cycle right after the write, and the output advances one step per clock after that.
- R6: A timed-mode write with repeat value N keeps `pat_active` high for exactly max(N,1) cycles. After that the mode reads back as off and the port returns to trace data.
- R7: The repeat readback always shows the last value written to it. The timed countdown never changes it.
- R8: When the mode is active but no pattern is enabled, `port_data` is all zeros and `pat_active` stays low.
- R9: When the mode is off, `pat_active` is low and `port_data` is `trace_data` masked to the port width.
- R10: `port_data` never has a bit set at or above the current port width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_count | input | 6 | Active port width in lanes, 1..PORT_W |
| trace_data | input | PORT_W | Normal trace word |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word: mode [17:16], enables [3:0] |
| ctrl_rdata | output | 32 | Live control readback |
| rpt_wr | input | 1 | Repeat value write strobe |
| rpt_wdata | input | CNT_W | Repeat value for timed mode |
| rpt_rdata | output | CNT_W | Programmed repeat value |
| port_data | output | PORT_W | Word driven to the trace port |
| pat_active | output | 1 | High while a pattern word is being driven |

## Verification
The assertions take two things for granted about the inputs. First, `lane_count` stays between 1 and `PORT_W`. Second, it holds steady while a pattern is running, because the bound on the step counter and the width mask both depend on that value.

The bench changes `lane_count` only while the mode is off or just before a control write restarts the sequence. It drives only the widths 1, 3, 8 and 32. Across those widths it sweeps all fifteen enable combinations in continuous mode and tries a range of timed repeat values.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding and field positions for the trace pattern generator.
// Assumes: control word layout with mode at [17:16] and pattern enables at [3:0].
package tpg_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_TIMED = 2'b01,
        MODE_CONT  = 2'b10
    } run_mode_t;

    localparam int MODE_LSB = 16;
    localparam int NUM_PAT  = 4;

    // Pattern indices, one per enable bit.
    localparam logic [1:0] PAT_WALK1 = 2'd0;
    localparam logic [1:0] PAT_WALK0 = 2'd1;
    localparam logic [1:0] PAT_ALT   = 2'd2;
    localparam logic [1:0] PAT_TOGL  = 2'd3;
endpackage

// File: rtl/tpg_ctrl.sv
`timescale 1ns/1ps
// Module: tpg_ctrl
// Holds the run mode, the pattern enables and the programmed repeat value, and runs
// the private timed-mode down-counter that returns the mode to off.
// Assumes: a control write reloads the counter from the repeat value stored before that edge.
module tpg_ctrl
    import tpg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [1:0]       wr_mode,
    input  logic [3:0]       wr_sel,
    input  logic             rpt_wr,
    input  logic [CNT_W-1:0] rpt_wdata,
    output run_mode_t        mode_q,
    output logic [3:0]       sel_q,
    output logic [CNT_W-1:0] rpt_q,
    output logic [CNT_W-1:0] live_q
);
    run_mode_t mode_dec;

    // Map the written mode field to a stored mode; 11 folds into continuous.
    always_comb begin
        case (wr_mode)
            2'b00:   mode_dec = MODE_OFF;
            2'b01:   mode_dec = MODE_TIMED;
            default: mode_dec = MODE_CONT;
        endcase
    end

    // Store the programmed repeat value.
    always_ff @(posedge clk) begin
        if (!rst_n)      rpt_q <= '0;
        else if (rpt_wr) rpt_q <= rpt_wdata;
    end

    // Update the mode and enables, and count timed mode down to its automatic stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            sel_q  <= '0;
            live_q <= '0;
        end else if (ctrl_wr) begin
            mode_q <= mode_dec;
            sel_q  <= wr_sel;
            live_q <= rpt_q;
        end else if (mode_q == MODE_TIMED) begin
            if (live_q <= CNT_W'(1)) mode_q <= MODE_OFF;
            else                      live_q <= live_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/tpg_seq.sv
`timescale 1ns/1ps
// Module: tpg_seq
// Tracks which enabled pattern is playing and the step within it. At the end of each
// sequence it moves to the next enabled pattern in ascending order, wrapping round.
// Assumes: width is 1..PORT_W and holds steady while run is high.
module tpg_seq
    import tpg_pkg::*;
#(
    parameter int WID_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [3:0]       load_sel,
    input  logic             run,
    input  logic [3:0]       sel,
    input  logic [WID_W-1:0] width,
    output logic [1:0]       pidx,
    output logic [WID_W-1:0] step
);
    // Next enabled pattern after cur, in ascending order with wrap; cur itself comes last.
    function automatic logic [1:0] next_sel(input logic [3:0] s, input logic [1:0] cur);
        logic [1:0] res;
        logic       hit;
        res = cur;
        hit = 1'b0;
        for (int off = 1; off <= NUM_PAT; off++) begin
            logic [1:0] cand;
            cand = cur + 2'(off);
            if (!hit && s[cand]) begin
                res = cand;
                hit = 1'b1;
            end
        end
        return res;
    endfunction

    logic             walking;
    logic [WID_W-1:0] last_step;
    logic             at_last;

    // Work out where the current pattern's sequence ends.
    always_comb begin
        walking   = (pidx == PAT_WALK1) || (pidx == PAT_WALK0);
        last_step = walking ? (width - WID_W'(1)) : WID_W'(1);
        at_last   = (step >= last_step);
    end

    // Advance the step and move to the next pattern at the end of a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pidx <= '0;
            step <= '0;
        end else if (restart) begin
            pidx <= next_sel(load_sel, 2'd3);
            step <= '0;
        end else if (run) begin
            if (at_last) begin
                step <= '0;
                pidx <= next_sel(sel, pidx);
            end else begin
                step <= step + WID_W'(1);
            end
        end
    end
endmodule

// File: rtl/tpg_word.sv
`timescale 1ns/1ps
// Module: tpg_word
// Builds the pattern word for a pattern index and step, masks it to the port width,
// and chooses between the pattern word, zeros and the trace word.
// Assumes: step < width whenever a walking pattern is active.
module tpg_word
    import tpg_pkg::*;
#(
    parameter int PORT_W = 32,
    parameter int WID_W  = 6
) (
    input  logic [1:0]        pidx,
    input  logic [WID_W-1:0]  step,
    input  logic [WID_W-1:0]  width,
    input  logic              mode_on,
    input  logic              active,
    input  logic [PORT_W-1:0] trace_data,
    output logic [PORT_W-1:0] port_data
);
    logic [PORT_W-1:0] mask;
    logic [PORT_W-1:0] alt_hi;
    logic [PORT_W-1:0] one_hot;
    logic [PORT_W-1:0] raw;

    // Per-lane masks: the enabled lanes and the odd-lane alternating word.
    always_comb begin
        for (int i = 0; i < PORT_W; i++) begin
            mask[i]   = (i < int'(width));
            alt_hi[i] = (i % 2 == 1);
        end
        one_hot = {{(PORT_W-1){1'b0}}, 1'b1} << step;
    end

    // Form the unmasked word for the current pattern and step.
    always_comb begin
        case (pidx)
            PAT_WALK1: raw = one_hot;
            PAT_WALK0: raw = ~one_hot;
            PAT_ALT:   raw = (step == '0) ? alt_hi : ~alt_hi;
            default:   raw = (step == '0) ? '1 : '0;
        endcase
    end

    // Drive the port: pattern word, zeros for an empty selection, or trace data.
    always_comb begin
        if (active)       port_data = raw & mask;
        else if (mode_on) port_data = '0;
        else              port_data = trace_data & mask;
    end
endmodule

// File: rtl/trace_pattern_gen.sv
`timescale 1ns/1ps
// Module: trace_pattern_gen (top)
// Test pattern source for a parallel trace port. It has off, timed and continuous
// modes, cycles through four pattern types, and masks every word to the lane count.
// Assumes: lane_count is 1..PORT_W and holds steady while a pattern runs.
module trace_pattern_gen
    import tpg_pkg::*;
#(
    parameter int PORT_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [$clog2(PORT_W+1)-1:0]   lane_count,
    input  logic [PORT_W-1:0]             trace_data,
    input  logic                          ctrl_wr,
    input  logic [31:0]                   ctrl_wdata,
    output logic [31:0]                   ctrl_rdata,
    input  logic                          rpt_wr,
    input  logic [CNT_W-1:0]              rpt_wdata,
    output logic [CNT_W-1:0]              rpt_rdata,
    output logic [PORT_W-1:0]             port_data,
    output logic                          pat_active
);
    localparam int WID_W = $clog2(PORT_W + 1);

    run_mode_t        mode_q;
    logic [3:0]       sel_q;
    logic [CNT_W-1:0] rpt_q;
    logic [CNT_W-1:0] live_q;
    logic [1:0]       pidx;
    logic [WID_W-1:0] step;
    logic             mode_on;
    logic             unused_wbits;

    assign unused_wbits = ^{ctrl_wdata[31:MODE_LSB+2], ctrl_wdata[MODE_LSB-1:4]};

    tpg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .wr_mode   (ctrl_wdata[MODE_LSB+1:MODE_LSB]),
        .wr_sel    (ctrl_wdata[3:0]),
        .rpt_wr    (rpt_wr),
        .rpt_wdata (rpt_wdata),
        .mode_q    (mode_q),
        .sel_q     (sel_q),
        .rpt_q     (rpt_q),
        .live_q    (live_q)
    );

    // Flag whether a mode is running and whether a pattern is actually being driven.
    always_comb begin
        mode_on    = (mode_q != MODE_OFF);
        pat_active = mode_on && (sel_q != 4'b0000);
    end

    tpg_seq #(.WID_W(WID_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (ctrl_wr),
        .load_sel (ctrl_wdata[3:0]),
        .run      (pat_active),
        .sel      (sel_q),
        .width    (lane_count),
        .pidx     (pidx),
        .step     (step)
    );

    tpg_word #(.PORT_W(PORT_W), .WID_W(WID_W)) u_word (
        .pidx       (pidx),
        .step       (step),
        .width      (lane_count),
        .mode_on    (mode_on),
        .active     (pat_active),
        .trace_data (trace_data),
        .port_data  (port_data)
    );

    // Assemble the readback words from the live state.
    always_comb begin
        ctrl_rdata                          = '0;
        ctrl_rdata[MODE_LSB+1:MODE_LSB]     = mode_q;
        ctrl_rdata[3:0]                     = sel_q;
        rpt_rdata                           = rpt_q;
    end
endmodule

// File: rtl/tpg_checker.sv
`timescale 1ns/1ps
// Module: tpg_checker
// Clocked properties for trace_pattern_gen, attached with bind.
// Assumes: lane_count is 1..PORT_W and holds steady while a pattern runs.
module tpg_checker #(
    parameter int PORT_W = 32,
    parameter int CNT_W  = 8,
    parameter int WID_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WID_W-1:0]  lane_count,
    input logic              ctrl_wr,
    input logic              rpt_wr,
    input logic [31:0]       ctrl_rdata,
    input logic [CNT_W-1:0]  rpt_rdata,
    input logic [PORT_W-1:0] port_data,
    input logic              pat_active,
    input logic [CNT_W-1:0]  live_q,
    input logic [1:0]        pidx,
    input logic [WID_W-1:0]  step
);
    logic [PORT_W-1:0] lane_mask;

    // Lanes allowed by the current width.
    always_comb begin
        for (int i = 0; i < PORT_W; i++) lane_mask[i] = (i < int'(lane_count));
    end

    assert_active_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pat_active |-> (ctrl_rdata[17:16] != 2'b00) && (ctrl_rdata[3:0] != 4'b0000));

    assert_empty_sel_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_rdata[17:16] != 2'b00) && (ctrl_rdata[3:0] == 4'b0000)) |-> (port_data == '0));

    assert_timed_stops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ctrl_rdata[17:16] == 2'b01) && (live_q <= CNT_W'(1)) && !ctrl_wr)
        |=> (ctrl_rdata[17:16] == 2'b00));

    assert_rpt_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rpt_wr |=> $stable(rpt_rdata));

    assert_mode_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[17:16] != 2'b11);

    assert_sel_playing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pat_active |-> ctrl_rdata[pidx]);

    assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pat_active |-> ((pidx < 2'd2) ? (step < lane_count) : (step < WID_W'(2))));

    assert_lane_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (port_data & ~lane_mask) == '0);
endmodule

bind trace_pattern_gen tpg_checker #(
    .PORT_W (PORT_W),
    .CNT_W  (CNT_W),
    .WID_W  ($clog2(PORT_W + 1))
) u_tpg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lane_count (lane_count),
    .ctrl_wr    (ctrl_wr),
    .rpt_wr     (rpt_wr),
    .ctrl_rdata (ctrl_rdata),
    .rpt_rdata  (rpt_rdata),
    .port_data  (port_data),
    .pat_active (pat_active),
    .live_q     (live_q),
    .pidx       (pidx),
    .step       (step)
);

// File: tb/test_trace_pattern_gen.sv
`timescale 1ns/1ps
module test_trace_pattern_gen;
    localparam int PORT_W = 32;
    localparam int CNT_W  = 8;
    localparam int WID_W  = $clog2(PORT_W + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WID_W-1:0]  lane_count = WID_W'(PORT_W);
    logic [PORT_W-1:0] trace_data = '0;
    logic              ctrl_wr = 1'b0;
    logic [31:0]       ctrl_wdata = '0;
    logic [31:0]       ctrl_rdata;
    logic              rpt_wr = 1'b0;
    logic [CNT_W-1:0]  rpt_wdata = '0;
    logic [CNT_W-1:0]  rpt_rdata;
    logic [PORT_W-1:0] port_data;
    logic              pat_active;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    trace_pattern_gen #(.PORT_W(PORT_W), .CNT_W(CNT_W)) i_trace_pattern_gen (
        .clk(clk), .rst_n(rst_n), .lane_count(lane_count), .trace_data(trace_data),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .rpt_wr(rpt_wr), .rpt_wdata(rpt_wdata), .rpt_rdata(rpt_rdata),
        .port_data(port_data), .pat_active(pat_active)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [PORT_W-1:0] lane_mask(input int w);
        return (w >= PORT_W) ? '1 : PORT_W'((64'd1 << w) - 64'd1);
    endfunction

    // Expected word at step k after a restart, for enable set s and width w.
    function automatic logic [PORT_W-1:0] model(input logic [3:0] s, input int w, input int k);
        int len [4];
        int sum;
        int r;
        logic [PORT_W-1:0] m;
        logic [PORT_W-1:0] res;
        len[0] = w; len[1] = w; len[2] = 2; len[3] = 2;
        sum = 0;
        for (int p = 0; p < 4; p++) if (s[p]) sum += len[p];
        r = k % sum;
        m = lane_mask(w);
        res = '0;
        for (int p = 0; p < 4; p++) begin
            if (s[p]) begin
                if (r >= 0 && r < len[p]) begin
                    case (p)
                        0: res = PORT_W'(64'd1 << r) & m;
                        1: res = ~PORT_W'(64'd1 << r) & m;
                        2: res = ((r == 0) ? {(PORT_W/8){8'hAA}} : {(PORT_W/8){8'h55}}) & m;
                        default: res = (r == 0) ? m : '0;
                    endcase
                end
                r -= len[p];
            end
        end
        return res;
    endfunction

    task automatic write_ctrl(input logic [1:0] mode, input logic [3:0] s);
        ctrl_wdata = {14'd0, mode, 12'd0, s};
        ctrl_wr = 1'b1;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic write_rpt(input logic [CNT_W-1:0] v);
        rpt_wdata = v;
        rpt_wr = 1'b1;
        tick();
        rpt_wr = 1'b0;
    endtask

    initial begin
        #(5.0 * 190000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int widths [4];
        int len_of;
        widths[0] = 1; widths[1] = 3; widths[2] = 8; widths[3] = 32;
        trace_data = 32'hDEAD_BEEF;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check("R1 ctrl", 64'(ctrl_rdata), 64'd0);
        check("R1 rpt", 64'(rpt_rdata), 64'd0);
        check("R1 active", 64'(pat_active), 64'd0);
        check("R1 data", 64'(port_data), 64'(32'hDEAD_BEEF));

        // R9: off mode passes trace data masked to each width
        for (int wi = 0; wi < 4; wi++) begin
            lane_count = WID_W'(widths[wi]);
            trace_data = 32'hA5C3_0F96 ^ 32'(wi);
            #1;
            check("R9 masked trace", 64'(port_data), 64'((32'hA5C3_0F96 ^ 32'(wi)) & lane_mask(widths[wi])));
            check("R9 active", 64'(pat_active), 64'd0);
        end

        // R3 R4 R5 R10: continuous mode, every enable set, several widths
        for (int wi = 0; wi < 4; wi++) begin
            lane_count = WID_W'(widths[wi]);
            for (int s = 1; s < 16; s++) begin
                len_of = (s[0] ? widths[wi] : 0) + (s[1] ? widths[wi] : 0)
                       + (s[2] ? 2 : 0) + (s[3] ? 2 : 0);
                write_ctrl(2'b10, 4'(s));
                check("R2 readback", 64'(ctrl_rdata), 64'({14'd0, 2'b10, 12'd0, 4'(s)}));
                for (int k = 0; k < 2 * len_of + 3; k++) begin
                    check("R3 R4 R5 word", 64'(port_data), 64'(model(4'(s), widths[wi], k)));
                    check("R10 active", 64'(pat_active), 64'd1);
                    tick();
                end
            end
        end
        lane_count = WID_W'(8);

        // R5: rewrite mid-sequence restarts at lowest enabled pattern
        write_ctrl(2'b10, 4'b0110);
        tick(); tick(); tick();
        write_ctrl(2'b10, 4'b0110);
        check("R5 restart", 64'(port_data), 64'(model(4'b0110, 8, 0)));

        // R2: code 11 acts as continuous and reads back as 10
        write_ctrl(2'b11, 4'b1000);
        check("R2 code11 readback", 64'(ctrl_rdata[17:16]), 64'd2);
        for (int k = 0; k < 6; k++) begin
            check("R2 code11 word", 64'(port_data), 64'(model(4'b1000, 8, k)));
            tick();
        end

        // R8: mode active with no patterns
        trace_data = 32'hFFFF_FFFF;
        write_ctrl(2'b10, 4'b0000);
        check("R8 zero data", 64'(port_data), 64'd0);
        check("R8 active", 64'(pat_active), 64'd0);
        write_ctrl(2'b01, 4'b0000);
        check("R8 timed zero data", 64'(port_data), 64'd0);
        write_ctrl(2'b00, 4'b0000);

        // R6 R7: timed mode lengths
        begin
            int nv [6];
            nv[0] = 0; nv[1] = 1; nv[2] = 2; nv[3] = 5; nv[4] = 17; nv[5] = 255;
            for (int i = 0; i < 6; i++) begin
                int cnt;
                int expn;
                write_rpt(CNT_W'(nv[i]));
                write_ctrl(2'b01, 4'b0101);
                cnt = 0;
                while (pat_active && cnt < 400) begin
                    check("R6 timed word", 64'(port_data), 64'(model(4'b0101, 8, cnt)));
                    cnt++;
                    tick();
                end
                expn = (nv[i] == 0) ? 1 : nv[i];
                check("R6 timed length", 64'(cnt), 64'(expn));
                check("R6 mode off", 64'(ctrl_rdata[17:16]), 64'd0);
                check("R6 trace back", 64'(port_data), 64'(trace_data & lane_mask(8)));
                check("R7 rpt readback", 64'(rpt_rdata), 64'(nv[i]));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule